// File: doc/BRIEF.md
# Dual-Pointer Post-Modify Address Generator

This block feeds a multiply-accumulate datapath with two operand addresses in every instruction cycle. One address comes from a general-purpose register, chosen from a 16-entry file. The other comes from one of two dedicated index registers. Both addresses are read out before they are modified. At the clock edge that ends the cycle, each pointer is written back after its own post-modification step. The step can hold the pointer, add or subtract two, or add or subtract an offset register. The general pointer and the index pointer each have their own pair of offset registers.

The index pointer may only reach a configurable internal-RAM window. The one exception is a move-class instruction, which lifts the restriction. When a non-move access falls outside the window, the block flags it in the same cycle. The general pointer may address all of memory and is never checked. A single synchronous write port loads the general registers, the offset registers and the index registers. Instruction decode, the arithmetic unit and the memory itself sit outside this block.

Top module: `dual_ptr_agu`

## Requirements
- R1: After reset, every general register, index register and offset register holds zero.
- R2: `gpr_addr` always shows the current value of the general register picked by `gpr_sel`. `idx_addr` always shows the index register picked by `idx_sel` (0 = first, 1 = second). Both values are taken before any modification.
- R3: The mode codes are: 0 leaves the pointer unchanged, 1 adds 2, 2 subtracts 2, 3 adds the selected offset and 4 subtracts it. Codes 5 to 7 also leave the pointer unchanged. All arithmetic wraps modulo 2^16.
- R4: The general pointer uses general offset register `gpr_qsel` (0 or 1). The index pointer uses index offset register `idx_qsel` (0 or 1). Neither pointer class ever uses the other class's offsets.
- R5: When `en` is high, the selected general pointer and the selected index pointer are both updated at the same clock edge.
- R6: While `en` is low, no register changes. This covers post-modification and the write port. The addresses are still driven.
- R7: The write port targets a register by `wr_addr`. Addresses 0-15 select general register 0-15. Addresses 16 and 17 select general offset 0 and 1. Addresses 18 and 19 select index offset 0 and 1. Addresses 20 and 21 select index register 0 and 1. Addresses 22-31 write nothing. A write wins over a post-modification of the same register in the same cycle. A post-modification in the same cycle as an offset write uses the offset value from before the write.
- R8: `range_err` is high in the same cycle, with no register delay, exactly when `en` is high, `move_class` is low and `idx_addr` lies below `RAM_LO` or above `RAM_HI`. The pointer update still takes place.
- R9: With `move_class` high, `range_err` stays low for any index address. The general pointer is never range-checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Cycle enable for all register changes |
| gpr_sel | input | 4 | General register used as pointer |
| gpr_mode | input | 3 | General pointer post-modify mode |
| gpr_qsel | input | 1 | General offset register select |
| idx_sel | input | 1 | Index register used as pointer |
| idx_mode | input | 3 | Index pointer post-modify mode |
| idx_qsel | input | 1 | Index offset register select |
| move_class | input | 1 | Move-class instruction; waives range check |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write target |
| wr_data | input | 16 | Register write value |
| gpr_addr | output | 16 | First operand address (general pointer) |
| idx_addr | output | 16 | Second operand address (index pointer) |
| range_err | output | 1 | Index address outside internal RAM window |

## Verification
The hardest situations to reach are three kinds of edge case. The first is the index pointer stepping exactly across either edge of the RAM window. The second is a pointer wrapping through 0x0000/0xFFFE. The third is a write colliding with a post-modification of the same register, or of the offset it uses. The stimulus first loads the index registers just inside and just outside `RAM_LO` and `RAM_HI` through the write port. It then steps them by two under both move and non-move instructions. It also aims deliberate write collisions at the active pointer and its offset. A long random phase follows, with write data biased toward the window edges. Every cycle is compared against a behavioural model kept in the bench.

// File: rtl/agu_pkg.sv
// Package: shared mode encoding and register-bank slot numbering for the
// dual-pointer address generator. Assumes 3-bit mode codes.
package agu_pkg;

    typedef enum logic [2:0] {
        PM_HOLD = 3'd0,
        PM_INC2 = 3'd1,
        PM_DEC2 = 3'd2,
        PM_ADDQ = 3'd3,
        PM_SUBQ = 3'd4
    } pm_mode_e;

    // Slot numbers inside the offset/index bank (write codes relative to NGPR)
    localparam int BANK_QR0   = 0;
    localparam int BANK_QX0   = 2;
    localparam int BANK_IDX0  = 4;
    localparam int BANK_SLOTS = 6;

endpackage

// File: rtl/agu_post_mod.sv
// Module: computes the post-modified value of one pointer.
// Pure combinational; wraps modulo 2^AW. Unknown codes hold the pointer.
module agu_post_mod
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  pm_mode_e      mode,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] STEP = AW'(2);

    // Select the post-modification arithmetic for the given mode.
    always_comb begin
        case (mode)
            PM_INC2: next = base + STEP;
            PM_DEC2: next = base - STEP;
            PM_ADDQ: next = base + offset;
            PM_SUBQ: next = base - offset;
            default: next = base;
        endcase
    end
endmodule

// File: rtl/agu_gpr_file.sv
// Module: general-purpose pointer register file with one read port,
// one post-modify update port and one explicit write port.
// Assumes the explicit write has priority over the update of the same entry.
module agu_gpr_file #(
    parameter int AW   = 16,
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    output logic [AW-1:0]           rd_data,
    input  logic                    upd_en,
    input  logic [AW-1:0]           upd_val,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data
);
    localparam int SELW = $clog2(NREG);

    logic [AW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [AW-1:0] q;
        logic          wr_hit;
        logic          upd_hit;

        assign wr_hit  = wr_en  && (wr_sel == SELW'(g));
        assign upd_hit = upd_en && (rd_sel == SELW'(g));

        // Hold one register: reset, explicit write, or post-modify update.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (wr_hit)  q <= wr_data;
            else if (upd_hit) q <= upd_val;
        end

        assign regs[g] = q;
    end

    // Read the currently selected pointer (value before modification).
    always_comb rd_data = regs[rd_sel];
endmodule

// File: rtl/agu_idx_bank.sv
// Module: bank of the two index pointers and both pairs of offset
// registers (general-pointer offsets and index-pointer offsets).
// Assumes write codes 0..5 map to slots; explicit write beats update.
module agu_idx_bank
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_sel,
    output logic [AW-1:0] idx_ptr,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_val,
    input  logic          qx_sel,
    output logic [AW-1:0] qx_val,
    input  logic          qr_sel,
    output logic [AW-1:0] qr_val,
    input  logic          wr_en,
    input  logic [2:0]    wr_code,
    input  logic [AW-1:0] wr_data
);
    logic [AW-1:0] slot [BANK_SLOTS];

    for (genvar g = 0; g < BANK_SLOTS; g++) begin : g_slot
        logic [AW-1:0] q;
        logic          wr_hit;
        logic          upd_hit;

        assign wr_hit = wr_en && (wr_code == 3'(g));
        if (g >= BANK_IDX0) begin : g_ptr
            assign upd_hit = upd_en && (idx_sel == 1'(g - BANK_IDX0));
        end else begin : g_off
            assign upd_hit = 1'b0;
        end

        // Hold one slot: reset, explicit write, or index post-modify.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (wr_hit)  q <= wr_data;
            else if (upd_hit) q <= upd_val;
        end

        assign slot[g] = q;
    end

    // Route the selected index pointer and the two selected offsets.
    always_comb begin
        idx_ptr = idx_sel ? slot[BANK_IDX0 + 1] : slot[BANK_IDX0];
        qx_val  = qx_sel  ? slot[BANK_QX0 + 1]  : slot[BANK_QX0];
        qr_val  = qr_sel  ? slot[BANK_QR0 + 1]  : slot[BANK_QR0];
    end
endmodule

// File: rtl/agu_range_chk.sv
// Module: flags an index address outside the internal-RAM window.
// Combinational; waived for move-class instructions; needs LO <= HI.
module agu_range_chk #(
    parameter int            AW = 16,
    parameter logic [AW-1:0] LO = '0,
    parameter logic [AW-1:0] HI = '1
) (
    input  logic [AW-1:0] addr,
    input  logic          active,
    input  logic          waive,
    output logic          err
);
    logic outside;

    // Compare the address against both window limits.
    always_comb begin
        outside = (addr < LO) || (addr > HI);
        err     = active && !waive && outside;
    end
endmodule

// File: rtl/dual_ptr_agu.sv
// Module: dual-pointer post-modify address generator (top).
// Drives a general-register operand address and an index-register operand
// address each cycle, post-modifies both pointers when enabled, decodes a
// single register write port and range-checks the index address.
// Assumes NGPR is a power of two of at least 8 (bank codes sit above it).
module dual_ptr_agu
    import agu_pkg::*;
#(
    parameter int                AW     = 16,
    parameter int                NGPR   = 16,
    parameter logic [AW-1:0]     RAM_LO = 16'hF600,
    parameter logic [AW-1:0]     RAM_HI = 16'hFDFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [$clog2(NGPR)-1:0]   gpr_sel,
    input  logic [2:0]                gpr_mode,
    input  logic                      gpr_qsel,
    input  logic                      idx_sel,
    input  logic [2:0]                idx_mode,
    input  logic                      idx_qsel,
    input  logic                      move_class,
    input  logic                      wr_en,
    input  logic [$clog2(NGPR):0]     wr_addr,
    input  logic [AW-1:0]             wr_data,
    output logic [AW-1:0]             gpr_addr,
    output logic [AW-1:0]             idx_addr,
    output logic                      range_err
);
    localparam int GSELW = $clog2(NGPR);
    localparam int WAW   = GSELW + 1;

    logic [AW-1:0] gpr_cur, gpr_next;
    logic [AW-1:0] idx_cur, idx_next;
    logic [AW-1:0] qr_val, qx_val;
    logic          gpr_wr, bank_wr;
    logic [2:0]    bank_code;

    // Decode the write port into general-file and bank strobes.
    always_comb begin
        gpr_wr    = en && wr_en && !wr_addr[WAW-1];
        bank_wr   = en && wr_en && wr_addr[WAW-1] &&
                    (wr_addr[GSELW-1:0] < GSELW'(BANK_SLOTS));
        bank_code = wr_addr[2:0];
    end

    agu_gpr_file #(.AW(AW), .NREG(NGPR)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (gpr_sel),
        .rd_data (gpr_cur),
        .upd_en  (en),
        .upd_val (gpr_next),
        .wr_en   (gpr_wr),
        .wr_sel  (wr_addr[GSELW-1:0]),
        .wr_data (wr_data)
    );

    agu_idx_bank #(.AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_sel (idx_sel),
        .idx_ptr (idx_cur),
        .upd_en  (en),
        .upd_val (idx_next),
        .qx_sel  (idx_qsel),
        .qx_val  (qx_val),
        .qr_sel  (gpr_qsel),
        .qr_val  (qr_val),
        .wr_en   (bank_wr),
        .wr_code (bank_code),
        .wr_data (wr_data)
    );

    agu_post_mod #(.AW(AW)) u_gpr_step (
        .base   (gpr_cur),
        .mode   (pm_mode_e'(gpr_mode)),
        .offset (qr_val),
        .next   (gpr_next)
    );

    agu_post_mod #(.AW(AW)) u_idx_step (
        .base   (idx_cur),
        .mode   (pm_mode_e'(idx_mode)),
        .offset (qx_val),
        .next   (idx_next)
    );

    agu_range_chk #(.AW(AW), .LO(RAM_LO), .HI(RAM_HI)) u_range (
        .addr   (idx_cur),
        .active (en),
        .waive  (move_class),
        .err    (range_err)
    );

    // Present the pre-modification pointers as operand addresses.
    always_comb begin
        gpr_addr = gpr_cur;
        idx_addr = idx_cur;
    end
endmodule

// File: rtl/agu_checker.sv
// Module: temporal checks on the address generator, bound to its top.
module agu_checker #(
    parameter int AW   = 16,
    parameter int NGPR = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [$clog2(NGPR)-1:0] gpr_sel,
    input logic [2:0]              gpr_mode,
    input logic                    idx_sel,
    input logic [2:0]              idx_mode,
    input logic                    move_class,
    input logic                    wr_en,
    input logic [$clog2(NGPR):0]   wr_addr,
    input logic [AW-1:0]           wr_data,
    input logic [AW-1:0]           gpr_addr,
    input logic [AW-1:0]           idx_addr,
    input logic                    range_err
);
    localparam int GSELW = $clog2(NGPR);
    localparam int WAW   = GSELW + 1;

    logic gpr_hit_w, idx_hit_w;
    always_comb begin
        gpr_hit_w = wr_en && (wr_addr == {1'b0, gpr_sel});
        idx_hit_w = wr_en && (wr_addr == WAW'(NGPR + 4) + WAW'(idx_sel));
    end

    p_idle_gpr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gpr_sel != $past(gpr_sel)) || (gpr_addr == $past(gpr_addr)));

    p_idle_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (idx_sel != $past(idx_sel)) || (idx_addr == $past(idx_addr)));

    p_gpr_inc2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gpr_mode == 3'd1 && !gpr_hit_w) |=>
        (gpr_sel != $past(gpr_sel)) || (gpr_addr == $past(gpr_addr) + AW'(2)));

    p_idx_dec2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && idx_mode == 3'd2 && !idx_hit_w) |=>
        (idx_sel != $past(idx_sel)) || (idx_addr == $past(idx_addr) - AW'(2)));

    p_gpr_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gpr_hit_w) |=>
        (gpr_sel != $past(gpr_sel)) || (gpr_addr == $past(wr_data)));

    p_err_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (en && !move_class));

    p_move_waiver_r9: assert property (@(posedge clk) disable iff (!rst_n)
        move_class |-> !range_err);
endmodule

bind dual_ptr_agu agu_checker #(.AW(AW), .NGPR(NGPR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .gpr_sel    (gpr_sel),
    .gpr_mode   (gpr_mode),
    .idx_sel    (idx_sel),
    .idx_mode   (idx_mode),
    .move_class (move_class),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .gpr_addr   (gpr_addr),
    .idx_addr   (idx_addr),
    .range_err  (range_err)
);

// File: tb/dual_ptr_agu_tb_top.sv
// Bench: behavioural reference model compared on every cycle.
module dual_ptr_agu_tb_top;
    localparam logic [15:0] LO = 16'hF600;
    localparam logic [15:0] HI = 16'hFDFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en, gpr_qsel, idx_sel, idx_qsel, move_class, wr_en;
    logic [3:0]  gpr_sel;
    logic [2:0]  gpr_mode, idx_mode;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data, gpr_addr, idx_addr;
    logic        range_err;

    always #2 clk = ~clk;

    dual_ptr_agu #(.AW(16), .NGPR(16), .RAM_LO(LO), .RAM_HI(HI)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .gpr_sel(gpr_sel),
        .gpr_mode(gpr_mode), .gpr_qsel(gpr_qsel), .idx_sel(idx_sel),
        .idx_mode(idx_mode), .idx_qsel(idx_qsel), .move_class(move_class),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gpr_addr(gpr_addr), .idx_addr(idx_addr), .range_err(range_err)
    );

    int gpr_m [16];
    int idx_m [2];
    int qr_m  [2];
    int qx_m  [2];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    function automatic int pm(int b, int m, int q);
        int r;
        case (m)
            1: r = b + 2;
            2: r = b - 2;
            3: r = b + q;
            4: r = b - q;
            default: r = b;
        endcase
        return r & 16'hFFFF;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit e, int gs, int gm, int gq, int is, int im, int iq,
                        bit mv, bit we, int wa, int wd, string tag);
        int ga, ia, gn, inx;
        bit er;
        en = e; gpr_sel = 4'(gs); gpr_mode = 3'(gm); gpr_qsel = 1'(gq);
        idx_sel = 1'(is); idx_mode = 3'(im); idx_qsel = 1'(iq);
        move_class = mv; wr_en = we; wr_addr = 5'(wa); wr_data = 16'(wd);
        #1;
        ga = gpr_m[gs];
        ia = idx_m[is];
        er = e && !mv && (ia < int'(LO) || ia > int'(HI));
        chk(tag, "gpr_addr", int'(gpr_addr), ga);
        chk(tag, "idx_addr", int'(idx_addr), ia);
        chk(tag, "range_err", int'(range_err), int'(er));
        gn  = pm(ga, gm, qr_m[gq]);
        inx = pm(ia, im, qx_m[iq]);
        @(posedge clk);
        if (e) begin
            gpr_m[gs] = gn;
            idx_m[is] = inx;
            if (we) begin
                wd = wd & 16'hFFFF;
                if (wa < 16)       gpr_m[wa] = wd;
                else if (wa < 18)  qr_m[wa-16] = wd;
                else if (wa < 20)  qx_m[wa-18] = wd;
                else if (wa < 22)  idx_m[wa-20] = wd;
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(int a, int d, string tag);
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, a, d, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) gpr_m[i] = 0;
        for (int i = 0; i < 2; i++) begin idx_m[i] = 0; qr_m[i] = 0; qx_m[i] = 0; end
        rst_n = 1'b0; en = 0; gpr_sel = 0; gpr_mode = 0; gpr_qsel = 0;
        idx_sel = 0; idx_mode = 0; idx_qsel = 0; move_class = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every pointer and (via add-offset) every offset
        for (int i = 0; i < 16; i++) step(0, i, 0, 0, i % 2, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 3, 0, 0, 3, 0, 1, 0, 0, 0, "R1");
        step(1, 0, 3, 1, 1, 4, 1, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R1");

        // R7: load registers through the write port, then read back (R2)
        for (int i = 0; i < 16; i++) wr(i, 16'h1000 + i * 16'h0111, "R7");
        wr(16, 16'h0010, "R7"); wr(17, 16'h0100, "R7");
        wr(18, 16'h0004, "R7"); wr(19, 16'h0300, "R7");
        wr(20, int'(LO) - 2, "R7"); wr(21, int'(HI), "R7");
        wr(25, 16'hDEAD, "R7");
        for (int i = 0; i < 16; i++) step(0, i, 0, 0, i % 2, 0, 0, 0, 0, 0, 0, "R2");

        // R8: step index 0 up across the low edge, index 1 across the high edge
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 0, 1, 2, 0, 0, 0, 0, 0, "R8");
        // R9: out of window under move class
        wr(21, 16'h0040, "R9");
        step(1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R9");

        // R3: wrap through zero and every mode code including 5-7
        wr(5, 16'hFFFE, "R3");
        step(1, 5, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        step(1, 5, 2, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        step(1, 5, 3, 1, 0, 0, 0, 1, 0, 0, 0, "R3");
        step(1, 5, 4, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        for (int m = 5; m < 8; m++) step(1, 5, m, 0, 0, m, 0, 1, 0, 0, 0, "R3");
        step(0, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");

        // R4: offset pairs are per class; R5: both updated in one cycle
        step(1, 6, 3, 0, 0, 3, 1, 1, 0, 0, 0, "R4");
        step(1, 6, 4, 1, 0, 3, 0, 1, 0, 0, 0, "R4");
        step(1, 6, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");

        // R7: collisions with the active pointer and with its offset
        step(1, 3, 1, 0, 0, 1, 0, 1, 1, 3, 16'hABCD, "R7");
        step(1, 3, 3, 0, 0, 0, 0, 1, 1, 16, 16'h0777, "R7");
        step(1, 3, 3, 0, 0, 1, 0, 1, 1, 20, 16'hF800, "R7");
        step(1, 3, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");

        // R6: disabled cycles with modes and writes requested change nothing
        step(0, 3, 1, 0, 0, 2, 0, 0, 1, 3, 16'h5555, "R6");
        step(0, 3, 3, 0, 0, 4, 0, 0, 1, 20, 16'h0000, "R6");
        step(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");

        // R5: random mix, writes biased toward the window edges
        for (int k = 0; k < 3000; k++) begin
            int wa, wd;
            wa = int'($urandom % 32);
            wd = (wa == 20 || wa == 21) ? int'(16'hF5F0 + ($urandom % 16'h0820))
                                        : int'($urandom % 65536);
            step(($urandom % 8) != 0, int'($urandom % 16), int'($urandom % 8),
                 int'($urandom % 2), int'($urandom % 2), int'($urandom % 8),
                 int'($urandom % 2), ($urandom % 4) == 0, ($urandom % 4) == 0,
                 wa, wd, "R5");
        end

        summary();
        $finish;
    end
endmodule